// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year spanning 2000 to 2099. A slow clock-enable pulse at 32768 Hz (`tick_32k`) drives a prescaler. Once every `PRESCALE` pulses the calendar advances by one second. Day, month and year rollovers follow the real month lengths, and February has 29 days in every year divisible by four.

Six alarm bytes sit beside the time bytes. The alarm flag is raised only when every alarm field equals the running time after an update; no field can be ignored. The status register collects sticky per-update events for the second, minute, hour and day, and the alarm flag. Software clears each of these by writing a one to it. Two interrupt outputs combine these flags with enable bits.

A status bit marks the prescaler period just before each update. Software polls it and then reads or writes a consistent set of fields. Everything is reached through a word-aligned byte register port that uses single-cycle writes and combinational reads.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 0x01, month 0x01, year 0x00. The control, status and interrupt-enable registers read 0x00 and both interrupt outputs are low.
- R2: While control bit 0 (run) is 1, the seconds field advances once for every `PRESCALE` pulses of `tick_32k`. While run is 0 the time holds. Status bit 1 always reads the run bit.
- R3: Seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: The day returns to 0x01 after the last day of the month: 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months except February. Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00.
- R5: February ends on 0x29 when the year is divisible by four and on 0x28 in other years.
- R6: Status bit 0 (busy) is 1 from the pulse that brings the prescaler to its last count until the pulse that performs the update. It is 0 at all other times, including whenever run is 0.
- R7: Each update sets status bit 2. An update that wraps the seconds also sets bit 3. One that wraps the minutes also sets bit 4. One that wraps the hours also sets bit 5. These bits stay set until software clears them.
- R8: Alarm bytes live at offsets 0x20 (seconds), 0x24, 0x28, 0x2C, 0x30 and 0x34 (year). Status bit 6 is set one clock after an update whose new time equals all six alarm bytes. A mismatch in any single field leaves it clear.
- R9: A write to the status register (0x44) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R10: `irq_alarm` equals status bit 6 ANDed with enable bit 3 at 0x48. `irq_timer` equals status bit 2 ANDed with enable bit 2.
- R11: Time bytes live at offsets 0x00 (seconds), 0x04, 0x08, 0x0C, 0x10 and 0x14 (year). A write loads the byte directly. A seconds write also restarts the prescaler, so the next update comes a full `PRESCALE` pulses later. Writes to other fields leave the prescaler phase alone.
- R12: Control is at 0x40 and stores only bit 0. The interrupt enable is at 0x48 and stores only bits 2 and 3. Other bits and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable pulse at the 32768 Hz rate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register (word aligned) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_timer | output | 1 | Per-second event interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
On every cycle the assertions check the following. The time holds between updates. The prescaler is frozen while the clock is stopped. Busy drops right after an update. The seconds byte wraps when it passes 0x59. The second event is recorded on each update. The alarm flag is sticky and only rises right after an update. The month-length table, leap-year Februaries, the year wrap, the exact busy window, the prescaler restart on a seconds write and the full six-field alarm match can only be shown by the bench. It runs directed calendar edges and randomly placed start times and compares them against its own binary calendar model.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

   localparam int NUM_FIELDS = 6;
   localparam int F_SEC = 0;
   localparam int F_MIN = 1;
   localparam int F_HR  = 2;
   localparam int F_DAY = 3;
   localparam int F_MON = 4;
   localparam int F_YR  = 5;

   // field order follows the register offsets: index = offset / 4
   typedef logic [NUM_FIELDS-1:0][7:0] rtcal_time_t;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // 10 = 2 (mod 4), so tens*2 + ones decides divisibility by four
   function automatic logic is_leap(input logic [7:0] yr);
      logic [4:0] s;
      s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
      return s[1:0] == 2'b00;
   endfunction

   function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtcal_prescaler.sv
module rtcal_prescaler #(
   parameter int unsigned PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic clr,
   output logic step,
   output logic busy
);
   localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
   localparam bit POW2 = (PRESCALE & (PRESCALE - 1)) == 0;

   logic [CW-1:0] cnt, cnt_inc;

   generate
      if (POW2) begin : g_wrap
         assign cnt_inc = cnt + 1'b1;
      end else begin : g_cmp
         assign cnt_inc = (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   endgenerate

   assign busy = run && (cnt == LAST);
   assign step = busy && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (run && tick) cnt <= cnt_inc;
   end

   assert_frozen_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !clr |=> $stable(cnt));
   assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> !busy);

endmodule

// File: rtl/rtcal_calendar.sv
module rtcal_calendar
   import rtcal_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        step,
   input  logic        wr_en,
   input  logic [2:0]  wr_idx,
   input  logic [7:0]  wr_data,
   output rtcal_time_t now,
   output logic [3:0]  carry
);
   rtcal_time_t adv, nxt;
   logic c_min, c_hr, c_day, c_mon, c_yr;

   always_comb begin
      c_min = now[F_SEC] == 8'h59;
      c_hr  = c_min && now[F_MIN] == 8'h59;
      c_day = c_hr && now[F_HR] == 8'h23;
      c_mon = c_day && now[F_DAY] >= last_day(now[F_MON], now[F_YR]);
      c_yr  = c_mon && now[F_MON] == 8'h12;
      adv = now;
      adv[F_SEC] = c_min ? 8'h00 : bcd_inc(now[F_SEC]);
      if (c_min) adv[F_MIN] = c_hr  ? 8'h00 : bcd_inc(now[F_MIN]);
      if (c_hr)  adv[F_HR]  = c_day ? 8'h00 : bcd_inc(now[F_HR]);
      if (c_day) adv[F_DAY] = c_mon ? 8'h01 : bcd_inc(now[F_DAY]);
      if (c_mon) adv[F_MON] = c_yr  ? 8'h01 : bcd_inc(now[F_MON]);
      if (c_yr)  adv[F_YR]  = (now[F_YR] == 8'h99) ? 8'h00 : bcd_inc(now[F_YR]);
      nxt = step ? adv : now;
      if (wr_en) nxt[wr_idx] = wr_data;
   end

   assign carry = step ? {c_day, c_hr, c_min, 1'b1} : 4'b0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now        <= '0;
         now[F_DAY] <= 8'h01;
         now[F_MON] <= 8'h01;
      end else begin
         now <= nxt;
      end
   end

   assert_hold_between_updates_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !wr_en |=> $stable(now));
   assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step && !wr_en && now[F_SEC] == 8'h59 |=> now[F_SEC] == 8'h00);

endmodule

// File: rtl/rtcal_alarm.sv
module rtcal_alarm
   import rtcal_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_idx,
   input  logic [7:0]  wr_data,
   input  rtcal_time_t now,
   output rtcal_time_t alarm,
   output logic        match
);
   logic [NUM_FIELDS-1:0] eq;

   generate
      for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           q <= 8'h00;
            else if (wr_en && wr_idx == 3'(g))    q <= wr_data;
         end
         assign alarm[g] = q;
         assign eq[g]    = (q == now[g]);
      end
   endgenerate

   assign match = &eq;

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
   import rtcal_pkg::*;
#(
   parameter int unsigned PRESCALE = 32768,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_timer,
   output logic              irq_alarm
);
   localparam int unsigned WI_W = ADDR_W - 2;
   localparam logic [WI_W-1:0] WI_CTRL = WI_W'(16);
   localparam logic [WI_W-1:0] WI_STAT = WI_W'(17);
   localparam logic [WI_W-1:0] WI_IE   = WI_W'(18);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
   endgenerate

   logic [WI_W-1:0] wi;
   logic [2:0]      idx;
   logic            aligned, time_sel, alm_sel;
   logic            run_q, ie_tmr, ie_alm, alm_flag, step_q;
   logic [3:0]      ev;
   logic            step, busy, match;
   logic [3:0]      carry;
   logic [7:0]      clr_mask, status;
   rtcal_time_t     now, alarm;

   assign wi       = bus_addr[ADDR_W-1:2];
   assign idx      = wi[2:0];
   assign aligned  = bus_addr[1:0] == 2'b00;
   assign time_sel = aligned && (wi >> 3) == '0 && idx < 3'd6;
   assign alm_sel  = aligned && (wi >> 3) == WI_W'(1) && idx < 3'd6;
   assign clr_mask = (bus_wr && aligned && wi == WI_STAT) ? bus_wdata : 8'h00;

   rtcal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick_32k), .run(run_q),
      .clr(bus_wr && time_sel && idx == 3'd0),
      .step(step), .busy(busy));

   rtcal_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .step(step),
      .wr_en(bus_wr && time_sel), .wr_idx(idx), .wr_data(bus_wdata),
      .now(now), .carry(carry));

   rtcal_alarm u_alm (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && alm_sel), .wr_idx(idx), .wr_data(bus_wdata),
      .now(now), .alarm(alarm), .match(match));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         ie_tmr   <= 1'b0;
         ie_alm   <= 1'b0;
         ev       <= '0;
         alm_flag <= 1'b0;
         step_q   <= 1'b0;
      end else begin
         step_q   <= step;
         ev       <= (ev & ~clr_mask[5:2]) | carry;
         alm_flag <= (alm_flag & ~clr_mask[6]) | (step_q & match);
         if (bus_wr && aligned && wi == WI_CTRL) run_q <= bus_wdata[0];
         if (bus_wr && aligned && wi == WI_IE) begin
            ie_tmr <= bus_wdata[2];
            ie_alm <= bus_wdata[3];
         end
      end
   end

   assign status = {1'b0, alm_flag, ev, run_q, busy};

   always_comb begin
      bus_rdata = 8'h00;
      if (time_sel)                       bus_rdata = now[idx];
      else if (alm_sel)                   bus_rdata = alarm[idx];
      else if (aligned && wi == WI_CTRL)  bus_rdata = {7'b0, run_q};
      else if (aligned && wi == WI_STAT)  bus_rdata = status;
      else if (aligned && wi == WI_IE)    bus_rdata = {4'b0, ie_alm, ie_tmr, 2'b00};
   end

   assign irq_timer = ev[0] & ie_tmr;
   assign irq_alarm = alm_flag & ie_alm;

   assert_sec_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ev[0]);
   assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      alm_flag && !clr_mask[6] |=> alm_flag);
   assert_alarm_after_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_flag) |-> $past(step_q));

endmodule

// File: tb/sim_bcd_calendar_rtc.sv
module sim_bcd_calendar_rtc;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_timer, irq_alarm;

   int n_chk = 0;
   int n_err = 0;
   int mt[6];
   int at[6];

   always #2.5 clk = ~clk;

   bcd_calendar_rtc #(.PRESCALE(P), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_timer(irq_timer), .irq_alarm(irq_alarm));

   function automatic logic [7:0] i2b(input int v);
      return 8'(((v / 10) * 16) + (v % 10));
   endfunction

   function automatic int mdays(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic adv(inout int t[6], output int evm);
      evm = 1;
      t[0]++;
      if (t[0] == 60) begin
         t[0] = 0; evm |= 2; t[1]++;
         if (t[1] == 60) begin
            t[1] = 0; evm |= 4; t[2]++;
            if (t[2] == 24) begin
               t[2] = 0; evm |= 8; t[3]++;
               if (t[3] > mdays(t[4], t[5])) begin
                  t[3] = 1; t[4]++;
                  if (t[4] > 12) begin t[4] = 1; t[5] = (t[5] + 1) % 100; end
               end
            end
         end
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_32k = 1'b1;
      end
      @(negedge clk);
      tick_32k = 1'b0;
      @(negedge clk);
   endtask

   task automatic load_time(input int y, input int mo, input int d, input int h, input int mi, input int s);
      mt[5] = y; mt[4] = mo; mt[3] = d; mt[2] = h; mt[1] = mi; mt[0] = s;
      for (int f = 5; f >= 0; f--) wr(8'(f * 4), i2b(mt[f]));
   endtask

   task automatic check_time(input string req);
      logic [7:0] v;
      for (int f = 0; f < 6; f++) begin
         rd(8'(f * 4), v);
         chk(req, v, i2b(mt[f]));
      end
   endtask

   task automatic one_sec_case(input string req, input int y, input int mo, input int d,
                               input int h, input int mi, input int s);
      int e;
      load_time(y, mo, d, h, mi, s);
      ticks(P);
      adv(mt, e);
      check_time(req);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int e, n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      mt = '{0, 0, 0, 1, 1, 0};
      check_time("R1");
      rd(8'h40, v); chk("R1 ctrl", v, 8'h00);
      rd(8'h44, v); chk("R1 status", v, 8'h00);
      rd(8'h48, v); chk("R1 ie", v, 8'h00);
      chk("R1 irq", {irq_timer, irq_alarm}, 0);

      // R12 register widths and unmapped offsets
      wr(8'h40, 8'hFF); rd(8'h40, v); chk("R12 ctrl", v, 8'h01);
      wr(8'h48, 8'hFF); rd(8'h48, v); chk("R12 ie", v, 8'h0C);
      wr(8'h48, 8'h00);
      rd(8'h18, v); chk("R12 unmapped", v, 8'h00);
      rd(8'h41, v); chk("R12 unaligned", v, 8'h00);

      // R2 stopped clock holds, status bit1 follows run
      wr(8'h40, 8'h00);
      ticks(10);
      rd(8'h00, v); chk("R2 stopped sec", v, 8'h00);
      rd(8'h44, v); chk("R2 run bit off", v & 8'h03, 8'h00);
      wr(8'h40, 8'h01);
      rd(8'h44, v); chk("R2 run bit on", v & 8'h02, 8'h02);

      // R6 busy window, R2 one step per P pulses
      wr(8'h00, 8'h10);
      ticks(P - 2);
      rd(8'h44, v); chk("R6 busy before window", v & 8'h01, 0);
      ticks(1);
      rd(8'h44, v); chk("R6 busy in window", v & 8'h01, 1);
      rd(8'h00, v); chk("R2 no update yet", v, 8'h10);
      ticks(1);
      rd(8'h44, v); chk("R6 busy after update", v & 8'h01, 0);
      rd(8'h00, v); chk("R2 update", v, 8'h11);

      // R11 minute write keeps phase, seconds write restarts it
      ticks(2);
      wr(8'h04, 8'h33);
      ticks(P - 2);
      rd(8'h00, v); chk("R11 phase kept", v, 8'h12);
      rd(8'h04, v); chk("R11 minute load", v, 8'h33);
      ticks(2);
      wr(8'h00, 8'h20);
      ticks(P - 2);
      rd(8'h00, v); chk("R11 phase restarted", v, 8'h20);
      ticks(2);
      rd(8'h00, v); chk("R11 full period", v, 8'h21);

      // R7 events and R9 write-one-to-clear
      wr(8'h44, 8'hFF);
      rd(8'h44, v); chk("R9 all cleared", v & 8'h7C, 0);
      load_time(7, 5, 12, 23, 59, 59);
      ticks(P);
      rd(8'h44, v); chk("R7 all events", v & 8'h3C, 8'h3C);
      wr(8'h44, 8'h04);
      rd(8'h44, v); chk("R9 clear one bit", v & 8'h3C, 8'h38);
      wr(8'h44, 8'h00);
      rd(8'h44, v); chk("R9 zero write", v & 8'h3C, 8'h38);
      wr(8'h44, 8'hFF);
      load_time(7, 5, 12, 10, 20, 30);
      ticks(P);
      rd(8'h44, v); chk("R7 second only", v & 8'h3C, 8'h04);

      // R10 timer interrupt
      wr(8'h48, 8'h04);
      chk("R10 timer irq on", irq_timer, 1);
      wr(8'h44, 8'h04);
      chk("R10 timer irq cleared", irq_timer, 0);
      wr(8'h48, 8'h00);

      // R3 R4 R5 directed calendar edges
      one_sec_case("R3 hour wrap", 15, 6, 3, 9, 59, 59);
      one_sec_case("R4 year wrap", 99, 12, 31, 23, 59, 59);
      one_sec_case("R4 april end", 21, 4, 30, 23, 59, 59);
      one_sec_case("R4 january end", 21, 1, 31, 23, 59, 59);
      one_sec_case("R5 leap feb 28", 24, 2, 28, 23, 59, 59);
      rd(8'h0C, v); chk("R5 leap day", v, 8'h29);
      one_sec_case("R5 leap feb 29", 0, 2, 29, 23, 59, 59);
      rd(8'h10, v); chk("R5 march after leap", v, 8'h03);
      one_sec_case("R5 plain feb 28", 23, 2, 28, 23, 59, 59);
      rd(8'h0C, v); chk("R5 no leap day", v, 8'h01);

      // R2 R3 R4 random spans
      for (int it = 0; it < 12; it++) begin
         int y, mo, d, h;
         y = $urandom_range(0, 99); mo = $urandom_range(1, 12);
         d = $urandom_range(1, mdays(mo, y)); h = $urandom_range(0, 23);
         if ($urandom_range(0, 1) == 1) begin d = mdays(mo, y); h = 23; end
         load_time(y, mo, d, h, $urandom_range(55, 59), $urandom_range(0, 59));
         n = $urandom_range(1, 90);
         ticks(n * P);
         for (int k = 0; k < n; k++) adv(mt, e);
         check_time("R4 random span");
      end

      // R8 alarm match, R10 alarm interrupt
      for (int it = 0; it < 4; it++) begin
         int k;
         load_time($urandom_range(0, 99), 12, 31, 23, 59, $urandom_range(30, 59));
         k = $urandom_range(2, 40);
         at = mt;
         for (int j = 0; j < k; j++) adv(at, e);
         for (int f = 0; f < 6; f++) wr(8'(8'h20 + f * 4), i2b(at[f]));
         wr(8'h44, 8'hFF);
         ticks((k - 1) * P);
         rd(8'h44, v); chk("R8 not yet", v & 8'h40, 0);
         ticks(P);
         rd(8'h44, v); chk("R8 alarm set", v & 8'h40, 8'h40);
         wr(8'h48, 8'h08);
         chk("R10 alarm irq on", irq_alarm, 1);
         wr(8'h48, 8'h00);
         chk("R10 alarm irq masked", irq_alarm, 0);
         ticks(3 * P);
         rd(8'h44, v); chk("R9 alarm sticky", v & 8'h40, 8'h40);
         wr(8'h44, 8'h40);
         rd(8'h44, v); chk("R9 alarm cleared", v & 8'h40, 0);
      end

      // R8 single-field mismatch
      load_time(50, 3, 3, 3, 3, 3);
      wr(8'h20, i2b(5)); wr(8'h24, i2b(3)); wr(8'h28, i2b(3));
      wr(8'h2C, i2b(3)); wr(8'h30, i2b(3)); wr(8'h34, i2b(51));
      wr(8'h44, 8'hFF);
      ticks(4 * P);
      rd(8'h44, v); chk("R8 year mismatch", v & 8'h40, 0);
      rd(8'h34, v); chk("R8 alarm readback", v, 8'h51);

      finish_run();
   end
endmodule